// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block schedules all-bank auto-refresh for one DRAM rank. A free-running interval timer marks a refresh as due once every `T_REFI` cycles. When a refresh is due and the sequencer is idle, it blocks new requests and waits for the accesses already in flight to finish. It then closes any open rows with a precharge-all command, issues the refresh command, and holds the rank busy for `T_RFC` cycles before it lets normal traffic through again.

Due times sit on a fixed grid: each one is `T_REFI` cycles after the one before, however long a sequence takes. A due time that passes while a sequence is still running is remembered and served as soon as the sequencer is idle again. If no row is open when draining ends, the precharge step is skipped. If a row is open, the refresh waits `T_RP` cycles after the precharge command and also waits for the precharge-done input.

Top module: `refresh_seq`

## Requirements
- R1: While reset is held and right after it, `seq_state` reads 0 and `block_req`, `pre_all_cmd`, `ref_cmd` and `ref_active` are all low. The state codes are idle 0, drain 1, precharge 2, refresh-run 3.
- R2: The first move from idle (0) to drain (1) is visible after exactly `T_REFI` rising edges counted from reset release.
- R3: While in drain (1) with `access_busy` high, the state stays in drain. The edge after `access_busy` is seen low moves it to precharge (2).
- R4: `block_req` is high in the drain, precharge and refresh-run states and low in idle.
- R5: If `bank_open` is high in the first precharge cycle, `pre_all_cmd` pulses for that one cycle only. With `pre_done` high, `ref_cmd` follows exactly `T_RP` cycles after that pulse.
- R6: After a precharge-all, `ref_cmd` is withheld while `pre_done` is low. It rises in the same cycle that `pre_done` rises, once `T_RP` has elapsed.
- R7: If `bank_open` is low in the first precharge cycle, `ref_cmd` is given in that same cycle and no `pre_all_cmd` is given.
- R8: `ref_cmd` is a one-cycle pulse. `ref_active` is high for exactly `T_RFC` cycles starting the next cycle, and then the state returns to idle.
- R9: The n-th due time falls at edge n·`T_REFI` after reset release, independent of when earlier sequences ended. An idle sequencer enters drain at that edge.
- R10: A due time that passes while a sequence is in progress is kept. The sequencer spends exactly one cycle in idle and then enters drain again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_busy | input | 1 | High while any access is still outstanding |
| bank_open | input | 1 | High while any bank has an open row |
| pre_done | input | 1 | High when the precharge-all has completed |
| block_req | output | 1 | Stops new requests from entering |
| pre_all_cmd | output | 1 | Precharge-all command pulse |
| ref_cmd | output | 1 | Refresh command pulse |
| ref_active | output | 1 | Rank busy with refresh (tRFC window) |
| seq_state | output | 2 | Sequencer state code |

## Verification
A wrong due-time base shows up at the second refresh. When an earlier drain was stretched, the drain entry moves off the `T_REFI` grid by the length of that stretch. A lost pending flag shows as idle lasting longer than one cycle after a late sequence ends, and a bad timer load shows within one sequence as `ref_cmd` off by cycles from `pre_all_cmd`, or as a `ref_active` window of the wrong length. Skipped or spurious precharge is visible the first precharge cycle through `pre_all_cmd` and `ref_cmd`.

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter int unsigned T_REFI = 200,
  parameter int unsigned T_RFC  = 20,
  parameter int unsigned T_RP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       access_busy,
  input  logic       bank_open,
  input  logic       pre_done,
  output logic       block_req,
  output logic       pre_all_cmd,
  output logic       ref_cmd,
  output logic       ref_active,
  output logic [1:0] seq_state
);
  localparam int unsigned IW   = (T_REFI > 1) ? $clog2(T_REFI) : 1;
  localparam int unsigned TMAX = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DRAIN = 2'd1, S_PRE = 2'd2, S_RUN = 2'd3} st_t;

  st_t           st;
  logic [IW-1:0] ival;
  logic [TW-1:0] tmr;
  logic          pending, pre_sent;
  logic          due;

  assign due         = (ival == IW'(T_REFI - 1));
  assign pre_all_cmd = (st == S_PRE) && !pre_sent && bank_open;
  assign ref_cmd     = (st == S_PRE) && (pre_sent ? (tmr == '0 && pre_done) : !bank_open);
  assign block_req   = (st != S_IDLE);
  assign ref_active  = (st == S_RUN);
  assign seq_state   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ival <= '0;
    else        ival <= due ? '0 : ival + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (st == S_IDLE) ? 1'b0 : (pending | due);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      pre_sent <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (due || pending) st <= S_DRAIN;
        S_DRAIN: if (!access_busy) begin
          st       <= S_PRE;
          pre_sent <= 1'b0;
        end
        S_PRE: begin
          if (pre_all_cmd) begin
            pre_sent <= 1'b1;
            tmr      <= TW'(T_RP - 1);
          end else if (ref_cmd) begin
            st  <= S_RUN;
            tmr <= TW'(T_RFC - 1);
          end else if (pre_sent && tmr != '0) begin
            tmr <= tmr - 1'b1;
          end
        end
        S_RUN: begin
          if (tmr == '0) st <= S_IDLE;
          else           tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int unsigned T_RFC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       access_busy,
  input logic       bank_open,
  input logic       pre_done,
  input logic       block_req,
  input logic       pre_all_cmd,
  input logic       ref_cmd,
  input logic       ref_active,
  input logic [1:0] seq_state
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (ref_active) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1 && access_busy) |=> seq_state == 2'd1);

  // R4
  block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_req) |-> seq_state == 2'd1);

  // R4
  block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(block_req) |-> $past(seq_state) == 2'd3);

  // R5
  pre_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_cmd |=> !pre_all_cmd);

  // R7
  ref_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> (!pre_all_cmd && block_req));

  // R8
  ref_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> (ref_active && !ref_cmd));

  // R8
  rfc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_active) |-> run_len == 16'(T_RFC));

  wire unused_ok = &{1'b0, bank_open, pre_done};
endmodule

bind refresh_seq refresh_seq_chk #(.T_RFC(T_RFC)) u_chk (.*);

// File: tb/sim_refresh_seq.sv
`timescale 1ns/1ps
module sim_refresh_seq;
  localparam int T_REFI = 200;
  localparam int T_RFC  = 20;
  localparam int T_RP   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 1'b0, bopen = 1'b0, pdone = 1'b0;
  logic blk, pre, refc, act;
  logic [1:0] st;
  int cyc = 0, pass_n = 0, tot_n = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  refresh_seq #(.T_REFI(T_REFI), .T_RFC(T_RFC), .T_RP(T_RP)) u0 (
    .clk(clk), .rst_n(rst_n), .access_busy(busy), .bank_open(bopen),
    .pre_done(pdone), .block_req(blk), .pre_all_cmd(pre), .ref_cmd(refc),
    .ref_active(act), .seq_state(st));

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    tot_n++;
    if (ok) pass_n++;
    else $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actv, expv, cyc);
  endtask

  task automatic wait_state(input logic [1:0] s);
    int n = 0;
    while (st != s && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(st == 2'd0 && !blk && !pre && !refc && !act, "R1", {blk, pre, refc, act, st}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st == 2'd0 && !blk, "R1", st, 0);
  endtask

  task automatic t_first_with_precharge();
    int p, n;
    busy = 1'b1; bopen = 1'b1; pdone = 1'b0;
    wait_state(2'd1);
    chk(cyc == T_REFI, "R2", cyc, T_REFI);
    chk(blk == 1'b1, "R4", blk, 1);
    repeat (10) @(negedge clk);
    chk(st == 2'd1, "R3", st, 1);
    busy = 1'b0;
    @(negedge clk);
    chk(st == 2'd2 && pre, "R5", {st, pre}, 5);
    p = cyc; pdone = 1'b1;
    @(negedge clk);
    chk(!pre, "R5", pre, 0);
    n = 0;
    while (!refc && n < 100) begin @(negedge clk); n++; end
    chk(cyc - p == T_RP, "R5", cyc - p, T_RP);
    @(negedge clk);
    chk(!refc, "R8", refc, 0);
    n = 0;
    while (act && n < 1000) begin n++; @(negedge clk); end
    chk(n == T_RFC, "R8", n, T_RFC);
    chk(st == 2'd0 && !blk, "R8", st, 0);
  endtask

  task automatic t_no_open_bank();
    bopen = 1'b0; pdone = 1'b0;
    wait_state(2'd1);
    chk(cyc == 2 * T_REFI, "R9", cyc, 2 * T_REFI);
    @(negedge clk);
    chk(st == 2'd2 && refc && !pre, "R7", {st, refc, pre}, 10);
    wait_state(2'd0);
  endtask

  task automatic t_pre_done_late();
    bopen = 1'b1; pdone = 1'b0;
    wait_state(2'd1);
    chk(cyc == 3 * T_REFI, "R9", cyc, 3 * T_REFI);
    @(negedge clk);
    chk(pre == 1'b1, "R5", pre, 1);
    repeat (T_RP + 5) @(negedge clk);
    chk(st == 2'd2 && !refc, "R6", {st, refc}, 4);
    pdone = 1'b1;
    #1;
    chk(refc == 1'b1, "R6", refc, 1);
    @(negedge clk);
    chk(act == 1'b1 && st == 2'd3, "R8", act, 1);
    wait_state(2'd0);
  endtask

  task automatic t_missed_due();
    busy = 1'b1; bopen = 1'b0;
    wait_state(2'd1);
    chk(cyc == 4 * T_REFI, "R9", cyc, 4 * T_REFI);
    repeat (T_REFI + 30) @(negedge clk);
    busy = 1'b0;
    wait_state(2'd0);
    chk(st == 2'd0, "R10", st, 0);
    @(negedge clk);
    chk(st == 2'd1, "R10", st, 1);
    wait_state(2'd0);
    wait_state(2'd1);
    chk(cyc == 6 * T_REFI, "R9", cyc, 6 * T_REFI);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tot_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end

  initial begin
    t_reset();
    t_first_with_precharge();
    t_no_open_bank();
    t_pre_done_late();
    t_missed_due();
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end
endmodule